// File: doc/BRIEF.md
# RGMII Transmit Clock Generator

This block builds the transmit clock for an RGMII link inside a design that runs on one fast reference clock. Two parent sources arrive as single-cycle tick strobes on that reference. A select bit picks one of them. A programmable integer divider follows, then a rate stage chosen by the link speed, then a fixed divide-by-two that makes a 50 % duty clock, and finally an enable gate. A separate skew stage shifts the finished clock by whole quarter periods, and it measures those quarters in reference cycles.

Software writes one control word that holds the source select, the divider code, the skew code and the enable. The written word sits in a shadow copy. The running configuration takes the shadow copy, or a new link speed, only after a falling edge of the clock and once the delayed output has drained low. As a result, a change never cuts a pulse short. The block drives two outputs: the delayed clock level, and a one-cycle strobe on each rising edge of that level. The strobe lets downstream logic use the clock as a clock enable.

Top module: `txclk_gen`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, `tx_clk` and `tx_stb` are low.
- R2: Control bit 0 selects the parent source: 0 counts ticks of `src_tick_a`, and 1 counts ticks of `src_tick_b`.
- R3: With the divider code N in 2..7 (control bits 3:1) and gigabit speed, the output period is 2·N selected ticks and the clock is high for N of them.
- R4: A divider code of 0 or 1 never causes a fault. It holds `tx_clk` low with no strobe for as long as it is in force.
- R5: With the enable bit (control bit 6) at 0, `tx_clk` stays low and `tx_stb` stays low.
- R6: `link_speed` scales the output rate with no control write. 2'b10 (or 2'b11) gives the base rate, 2'b01 gives one fifth of it, and 2'b00 gives one fiftieth.
- R7: A change of control word or speed takes effect only after a falling edge, once the delayed output is low. No high or low pulse is shorter than the shorter half period of the old and new settings.
- R8: Skew code d (control bits 5:4) delays every rising edge after the first one by d·floor(H/2) reference cycles. H is the half period in reference cycles, measured once after each start.
- R9: `tx_stb` is high for exactly one cycle on each rising edge of `tx_clk`, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_tick_a | input | 1 | Tick strobe of parent source 0 |
| src_tick_b | input | 1 | Tick strobe of parent source 1 |
| link_speed | input | 2 | Link speed: 10 = gigabit, 01 = 100M, 00 = 10M |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_wdata | input | 7 | Control word: [6] enable, [5:4] skew, [3:1] divider, [0] source |
| tx_clk | output | 1 | Delayed transmit clock level |
| tx_stb | output | 1 | One-cycle strobe at each rising edge of `tx_clk` |

## Verification
The skew stage is the hardest part to observe, for two reasons. Its quarter-period step is measured from the running clock, and the undelayed clock never reaches a port. The bench therefore resets the block and applies the same configuration several times, changing only the skew code. It time-stamps the fourth rising strobe after reset in each run and compares the stamps with the run at code zero. Mid-run changes are checked by issuing writes at fixed cycles while every completed high and low run length is logged, so any runt shows up directly.

// File: rtl/txclk_pkg.sv
package txclk_pkg;

    localparam int DIV_W  = 3;
    localparam int SKEW_W = 2;

    typedef enum logic [1:0] {
        SPD_10M  = 2'b00,
        SPD_100M = 2'b01,
        SPD_1G   = 2'b10,
        SPD_RSVD = 2'b11
    } link_speed_e;

    // control word, MSB first: enable, skew, divider, source select
    typedef struct packed {
        logic              en;
        logic [SKEW_W-1:0] skew;
        logic [DIV_W-1:0]  div;
        logic              src;
    } txclk_cfg_t;

    localparam int CFG_W = $bits(txclk_cfg_t);

endpackage

// File: rtl/txclk_cfg_ctl.sv
module txclk_cfg_ctl
    import txclk_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    input  logic [1:0]       speed_in,
    input  logic             fall_evt,
    input  logic             skew_idle,
    output txclk_cfg_t       act,
    output logic [1:0]       act_speed,
    output logic             run
);

    typedef struct packed {
        txclk_cfg_t shadow;
        txclk_cfg_t act;
        logic [1:0] speed;
        logic       hold;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic       live;
    logic       pend;

    always_comb begin
        st_d = st_q;
        live = st_q.act.en && (st_q.act.div >= DIV_W'(2));
        pend = (st_q.shadow != st_q.act) || (speed_in != st_q.speed);

        if (wr_en) begin
            st_d.shadow = txclk_cfg_t'(wr_data);
        end

        if (st_q.hold) begin
            // wait until the delayed output has drained, then restart
            if (skew_idle) begin
                st_d.act   = st_q.shadow;
                st_d.speed = speed_in;
                st_d.hold  = 1'b0;
            end
        end else if (!live) begin
            st_d.act   = st_q.shadow;
            st_d.speed = speed_in;
        end else if (fall_evt && pend) begin
            st_d.hold = 1'b1;
        end

        run = live && !st_q.hold;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.shadow <= '0;
            st_q.act    <= '0;
            st_q.speed  <= SPD_1G;
            st_q.hold   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign act       = st_q.act;
    assign act_speed = st_q.speed;

endmodule

// File: rtl/txclk_div_chain.sv
module txclk_div_chain
    import txclk_pkg::*;
#(
    parameter int RATE_FE = 5,
    parameter int RATE_TE = 50
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_a,
    input  logic             tick_b,
    input  logic             run,
    input  logic             src_sel,
    input  logic [DIV_W-1:0] div_code,
    input  logic [1:0]       speed,
    output logic             flip,
    output logic             fall
);

    localparam int SPD_CW = (RATE_TE > 2) ? $clog2(RATE_TE) : 1;

    typedef struct packed {
        logic [DIV_W-1:0]  div_cnt;
        logic [SPD_CW-1:0] spd_cnt;
        logic              lvl;
    } chain_state_t;

    chain_state_t      st_d, st_q;
    logic              tick;
    logic              div_hit;
    logic              spd_hit;
    logic [SPD_CW-1:0] lim_m1;

    always_comb begin
        case (link_speed_e'(speed))
            SPD_10M:  lim_m1 = SPD_CW'(RATE_TE - 1);
            SPD_100M: lim_m1 = SPD_CW'(RATE_FE - 1);
            default:  lim_m1 = '0;
        endcase
    end

    always_comb begin
        st_d    = st_q;
        tick    = src_sel ? tick_b : tick_a;
        div_hit = run && tick && (st_q.div_cnt == (div_code - DIV_W'(1)));
        spd_hit = div_hit && (st_q.spd_cnt == lim_m1);

        if (!run) begin
            st_d = '0;
        end else begin
            if (tick) begin
                st_d.div_cnt = div_hit ? '0 : st_q.div_cnt + DIV_W'(1);
            end
            if (div_hit) begin
                st_d.spd_cnt = spd_hit ? '0 : st_q.spd_cnt + SPD_CW'(1);
            end
            if (spd_hit) begin
                st_d.lvl = ~st_q.lvl;
            end
        end

        flip = spd_hit;
        fall = spd_hit && st_q.lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/txclk_skew.sv
module txclk_skew
    import txclk_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              flip,
    input  logic [SKEW_W-1:0] skew_code,
    output logic              dlvl,
    output logic              stb,
    output logic              idle
);

    localparam int DLY_W = CNT_W + SKEW_W;
    localparam int SLOTS = 2;

    typedef struct packed {
        logic [CNT_W-1:0]            since;
        logic                        first;
        logic                        step_ok;
        logic [CNT_W-1:0]            step;
        logic [SLOTS-1:0]            busy;
        logic [SLOTS-1:0][DLY_W-1:0] cnt;
        logic                        dlvl;
        logic                        stb;
    } skew_state_t;

    skew_state_t                 st_d, st_q;
    logic [DLY_W-1:0]            dly;
    logic                        dly_zero;
    logic                        expire;
    logic [CNT_W:0]              half_len;
    logic [SLOTS-1:0][DLY_W-1:0] dec;

    generate
        for (genvar g = 0; g < SLOTS; g++) begin : g_dec
            assign dec[g] = st_q.busy[g] ? st_q.cnt[g] - DLY_W'(1) : '0;
        end
    endgenerate

    always_comb begin
        st_d     = st_q;
        idle     = (st_q.busy == '0) && !st_q.dlvl;
        dly      = st_q.step_ok ? DLY_W'(skew_code) * DLY_W'(st_q.step) : '0;
        dly_zero = (dly == '0);
        expire   = st_q.busy[0] && (st_q.cnt[0] == DLY_W'(1));
        half_len = {1'b0, st_q.since} + {{CNT_W{1'b0}}, 1'b1};

        st_d.since = (st_q.since == '1) ? st_q.since : st_q.since + CNT_W'(1);

        // oldest pending edge sits in slot 0
        if (expire) begin
            st_d.busy = {1'b0, st_q.busy[1]};
            st_d.cnt  = {DLY_W'(0), dec[1]};
        end else begin
            st_d.busy = st_q.busy;
            st_d.cnt  = dec;
        end

        if (!run && idle) begin
            st_d.first   = 1'b0;
            st_d.step_ok = 1'b0;
            st_d.step    = '0;
        end

        if (flip) begin
            st_d.since = '0;
            if (!st_q.first) begin
                st_d.first = 1'b1;
            end else if (!st_q.step_ok) begin
                st_d.step_ok = 1'b1;
                st_d.step    = half_len[CNT_W:1];
            end
            if (!dly_zero) begin
                if (!st_d.busy[0]) begin
                    st_d.busy[0] = 1'b1;
                    st_d.cnt[0]  = dly;
                end else begin
                    st_d.busy[1] = 1'b1;
                    st_d.cnt[1]  = dly;
                end
            end
        end

        st_d.dlvl = st_q.dlvl ^ (expire || (flip && dly_zero));
        st_d.stb  = st_d.dlvl && !st_q.dlvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dlvl = st_q.dlvl;
    assign stb  = st_q.stb;

endmodule

// File: rtl/txclk_gen.sv
module txclk_gen
    import txclk_pkg::*;
#(
    parameter int RATE_FE = 5,
    parameter int RATE_TE = 50,
    parameter int CNT_W   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_tick_a,
    input  logic             src_tick_b,
    input  logic [1:0]       link_speed,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic             tx_clk,
    output logic             tx_stb
);

    txclk_cfg_t act;
    logic [1:0] act_speed;
    logic       run;
    logic       core_flip;
    logic       core_fall;
    logic       skew_idle;

    txclk_cfg_ctl u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (cfg_we),
        .wr_data   (cfg_wdata),
        .speed_in  (link_speed),
        .fall_evt  (core_fall),
        .skew_idle (skew_idle),
        .act       (act),
        .act_speed (act_speed),
        .run       (run)
    );

    txclk_div_chain #(
        .RATE_FE (RATE_FE),
        .RATE_TE (RATE_TE)
    ) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_a   (src_tick_a),
        .tick_b   (src_tick_b),
        .run      (run),
        .src_sel  (act.src),
        .div_code (act.div),
        .speed    (act_speed),
        .flip     (core_flip),
        .fall     (core_fall)
    );

    txclk_skew #(
        .CNT_W (CNT_W)
    ) u_skew (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (run),
        .flip      (core_flip),
        .skew_code (act.skew),
        .dlvl      (tx_clk),
        .stb       (tx_stb),
        .idle      (skew_idle)
    );

endmodule

// File: rtl/txclk_gen_chk.sv
module txclk_gen_chk
    import txclk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       tx_clk,
    input logic       tx_stb,
    input txclk_cfg_t act_cfg
);

    // R9
    stb_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |-> tx_clk);

    // R9
    stb_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_stb |=> !tx_stb);

    // R4
    div_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_cfg.div < DIV_W'(2)) |-> !tx_clk);

    // R5
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !act_cfg.en |-> !tx_clk);

    // R7
    cfg_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(act_cfg) |-> !tx_clk);

endmodule

bind txclk_gen txclk_gen_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .tx_clk  (tx_clk),
    .tx_stb  (tx_stb),
    .act_cfg (act)
);

// File: tb/txclk_gen_bench.sv
module txclk_gen_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       src_tick_a = 1'b1;
    logic       src_tick_b = 1'b0;
    logic [1:0] link_speed = 2'b10;
    logic       cfg_we = 1'b0;
    logic [6:0] cfg_wdata = '0;
    logic       tx_clk;
    logic       tx_stb;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    txclk_gen u_txclk_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_tick_a (src_tick_a),
        .src_tick_b (src_tick_b),
        .link_speed (link_speed),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .tx_clk     (tx_clk),
        .tx_stb     (tx_stb)
    );

    always #4 clk = ~clk;

    // source b ticks every second reference cycle
    always @(negedge clk) src_tick_b <= ~src_tick_b;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<100000", cyc);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [6:0] pack(bit en, bit [1:0] sk, bit [2:0] dv, bit s);
        return {en, sk, dv, s};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic chk_ge(input string req, input int act, input int lo);
        n_chk++;
        if (act < lo) begin
            n_bad++;
            $display("FAIL %s: actual=%0d expected>=%0d", req, act, lo);
        end
    endtask

    task automatic wr(input logic [6:0] w);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = w;
        @(negedge clk);
        cfg_we    = 1'b0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // period and high time between two rising strobes
    task automatic meas(output int per, output int hi);
        int n = 0;
        while (!tx_stb && n < 5000) begin
            @(negedge clk);
            n++;
        end
        per = 0;
        hi  = 0;
        do begin
            if (tx_clk) hi++;
            per++;
            @(negedge clk);
        end while (!tx_stb && per < 5000);
    endtask

    task automatic t_reset();
        rst_n  = 1'b0;
        cfg_we = 1'b0;
        link_speed = 2'b10;
        settle(4);
        chk("R1 clk in reset", int'(tx_clk), 0);
        chk("R1 stb in reset", int'(tx_stb), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 clk after reset", int'(tx_clk), 0);
        chk("R1 stb after reset", int'(tx_stb), 0);
    endtask

    task automatic t_divider();
        int per, hi;
        for (int dv = 2; dv <= 7; dv++) begin
            wr(pack(1, 0, 3'(dv), 0));
            settle(40);
            meas(per, hi);
            chk($sformatf("R3 period div=%0d", dv), per, 2 * dv);
            chk($sformatf("R3 high div=%0d", dv), hi, dv);
        end
    endtask

    task automatic t_source();
        int per, hi;
        wr(pack(1, 0, 3, 1));
        settle(60);
        meas(per, hi);
        chk("R2 period on source b", per, 12);
        chk("R2 high on source b", hi, 6);
        wr(pack(1, 0, 3, 0));
        settle(40);
        meas(per, hi);
        chk("R2 period back on source a", per, 6);
    endtask

    task automatic t_speed();
        int per, hi;
        wr(pack(1, 0, 3, 0));
        settle(20);
        link_speed = 2'b01;
        settle(100);
        meas(per, hi);
        chk("R6 period 100M", per, 30);
        chk("R6 high 100M", hi, 15);
        link_speed = 2'b00;
        settle(400);
        meas(per, hi);
        chk("R6 period 10M", per, 300);
        chk("R6 high 10M", hi, 150);
        link_speed = 2'b10;
        settle(400);
        meas(per, hi);
        chk("R6 period back to gigabit", per, 6);
        link_speed = 2'b11;
        settle(40);
        meas(per, hi);
        chk("R6 period reserved speed", per, 6);
        link_speed = 2'b10;
    endtask

    task automatic quiet(input string req);
        int nh = 0, ns = 0;
        settle(30);
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (tx_clk) nh++;
            if (tx_stb) ns++;
        end
        chk({req, " high samples"}, nh, 0);
        chk({req, " strobes"}, ns, 0);
    endtask

    task automatic t_freeze();
        wr(pack(1, 0, 0, 0));
        quiet("R4 div code 0");
        wr(pack(1, 0, 4, 0));
        settle(20);
        wr(pack(1, 0, 1, 0));
        quiet("R4 div code 1");
        wr(pack(0, 0, 5, 0));
        quiet("R5 enable off");
    endtask

    task automatic t_glitch();
        int   len = 0, mn = 1000, runs = 0;
        logic prev;
        bit   started = 0;
        wr(pack(1, 0, 3, 0));
        settle(40);
        prev = tx_clk;
        for (int c = 0; c < 400; c++) begin
            if (c == 101) begin cfg_we = 1'b1; cfg_wdata = pack(1, 0, 6, 0); end
            else if (c == 193) begin cfg_we = 1'b1; cfg_wdata = pack(1, 1, 4, 0); end
            else if (c == 287) begin cfg_we = 1'b1; cfg_wdata = pack(1, 0, 0, 0); end
            else cfg_we = 1'b0;
            @(negedge clk);
            if (tx_clk == prev) len++;
            else begin
                if (started) begin
                    runs++;
                    if (len < mn) mn = len;
                end
                started = 1;
                len  = 1;
                prev = tx_clk;
            end
        end
        cfg_we = 1'b0;
        chk_ge("R7 shortest pulse across changes", mn, 3);
        chk_ge("R7 pulses seen", runs, 20);
        chk("R4 stopped after mid-run write", int'(tx_clk), 0);
    endtask

    task automatic t_skew();
        int t[4];
        for (int d = 0; d < 4; d++) begin
            int cnt = 0, nst = 0;
            t_reset();
            wr(pack(1, 2'(d), 4, 0));
            while (nst < 4 && cnt < 2000) begin
                @(negedge clk);
                cnt++;
                if (tx_stb) nst++;
            end
            t[d] = cnt;
            if (d == 3) begin
                int ns = 0, nh = 0;
                settle(40);
                for (int c = 0; c < 160; c++) begin
                    @(negedge clk);
                    if (tx_stb) ns++;
                    if (tx_clk) nh++;
                end
                chk("R9 strobes in 20 periods", ns, 20);
                chk("R8 high samples with skew", nh, 80);
            end
        end
        for (int d = 1; d < 4; d++) begin
            chk($sformatf("R8 edge shift code %0d", d), t[d] - t[0], 2 * d);
        end
    endtask

    initial begin
        t_reset();
        t_divider();
        t_source();
        t_speed();
        t_freeze();
        t_glitch();
        t_skew();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule